// File: doc/BRIEF.md
# Six-Channel DMA Priority Arbiter

This block decides which of six DMA channels may drive a shared transfer engine. Each channel raises a request line when it has work. The arbiter picks one requesting channel and grants it. The grant stays with that channel until the channel signals, with a one-cycle unit-done pulse, that it has finished its unit of work. Arbitration then runs again.

A two-bit mode input selects the policy at run time. Three of the modes are fixed priority orders, two of which are irregular. The fourth mode rotates service among the requesting channels. A controller enable and a halt flag gate the whole block. Clearing the enable withdraws any grant at once. Setting the halt flag stops new grants but lets a grant already held run to completion.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, no channel is granted, `grant` is 0, `grant_valid` is 0 and `grant_idx` is 0. The round-robin history starts as if channel 5 was served last.
- R2: With `ctl_mode` = 0, the highest-ranked requester wins in the order 0,1,2,3,4,5 (highest first).
- R3: With `ctl_mode` = 1, the ranking is 0,2,3,1,4,5 (highest first).
- R4: With `ctl_mode` = 2, the ranking is 2,0,1,3,4,5 (highest first).
- R5: With `ctl_mode` = 3, the search starts at the channel after the one granted most recently and wraps from 5 to 0.
- R6: While `ctl_en` is 0, no grant is issued. A held grant disappears from the outputs in the same cycle and is released at the next clock edge.
- R7: While `ctl_halt` is 1, no new grant is issued. A grant already held stays in place until it is released.
- R8: A grant is held until the granted channel pulses `unit_done`. A `unit_done` pulse from any other channel, and any change in the other requests, has no effect. After a release, `grant` is 0 for one cycle and the next edge arbitrates again.
- R9: `grant` is one-hot or all zero, and never names a channel whose request is low. If the holder drops its request, its grant is released.
- R10: `grant_valid` is the OR of `grant`. `grant_idx` holds the binary number of the granted channel, or 0 when there is no grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 6 | Request line per channel, bit n = channel n |
| unit_done | input | 6 | One-cycle completion pulse per channel |
| ctl_en | input | 1 | Controller enable |
| ctl_halt | input | 1 | Halt flag; blocks new grants |
| ctl_mode | input | 2 | Policy: 0,1,2 fixed orders, 3 round robin |
| grant | output | 6 | One-hot grant |
| grant_valid | output | 1 | Some channel is granted |
| grant_idx | output | 3 | Number of the granted channel |

## Verification
The hardest case to reach is the rotation in R5. Its result depends on a history that the ports never show. The bench starts from reset, so the history is known, and walks a full circle with all six channels requesting. It then narrows the requests to two widely spaced channels, which forces both a skip and a wrap from 5 to 0. The halt case is also delicate, because a grant must outlive the halt while no new grant appears. The bench reaches it by asserting halt while a grant is held, then releasing that grant while halt is still set.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int CH_COUNT = 6;
    localparam int IDX_W    = $clog2(CH_COUNT);
    localparam int FIXED_MODES = 3;

    typedef logic [CH_COUNT-1:0] ch_vec_t;
    typedef logic [IDX_W-1:0]    ch_idx_t;

    typedef enum logic [1:0] {
        POL_ASCEND  = 2'd0,
        POL_TWO_UP  = 2'd1,
        POL_LEAD_2  = 2'd2,
        POL_ROTATE  = 2'd3
    } policy_e;

    typedef struct packed {
        logic    valid;
        ch_idx_t idx;
    } pick_t;

    // Channel that holds a given rank (0 = highest) under a fixed policy.
    function automatic ch_idx_t rank_to_chan(input int policy, input int rank);
        int ch;
        ch = rank;
        if (policy == 1) begin
            case (rank)
                1: ch = 2;
                2: ch = 3;
                3: ch = 1;
                default: ch = rank;
            endcase
        end else if (policy == 2) begin
            case (rank)
                0: ch = 2;
                1: ch = 0;
                2: ch = 1;
                default: ch = rank;
            endcase
        end
        return ch_idx_t'(ch);
    endfunction

endpackage

// File: rtl/dma_arb_fixed_pick.sv
module dma_arb_fixed_pick
    import dma_arb_pkg::*;
#(
    parameter int POLICY = 0
) (
    input  ch_vec_t req,
    output pick_t   pick
);
    always_comb begin
        pick = '0;
        // Lowest rank scanned last so it overrides the others.
        for (int r = CH_COUNT - 1; r >= 0; r--) begin
            if (req[rank_to_chan(POLICY, r)]) begin
                pick.valid = 1'b1;
                pick.idx   = rank_to_chan(POLICY, r);
            end
        end
    end
endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick
    import dma_arb_pkg::*;
(
    input  ch_vec_t req,
    input  ch_idx_t last,
    output pick_t   pick
);
    always_comb begin
        int c;
        pick = '0;
        // Offset 1 scanned last so the channel after `last` wins.
        for (int k = CH_COUNT; k >= 1; k--) begin
            c = (int'(last) + k) % CH_COUNT;
            if (req[c]) begin
                pick.valid = 1'b1;
                pick.idx   = ch_idx_t'(c);
            end
        end
    end
endmodule

// File: rtl/dma_arb_hold.sv
module dma_arb_hold
    import dma_arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_vec_t req,
    input  ch_vec_t unit_done,
    input  logic    ctl_en,
    input  logic    ctl_halt,
    input  pick_t   win,
    output logic    busy,
    output ch_idx_t owner,
    output ch_idx_t last
);
    logic may_grant;
    logic drop;

    assign may_grant = ctl_en && !ctl_halt;
    assign drop      = !ctl_en || !req[owner] || unit_done[owner];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            owner <= '0;
            last  <= ch_idx_t'(CH_COUNT - 1);
        end else if (busy) begin
            if (drop) busy <= 1'b0;
        end else if (may_grant && win.valid) begin
            busy  <= 1'b1;
            owner <= win.idx;
            last  <= win.idx;
        end
    end

    assert_halt_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctl_en && !ctl_halt));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && ctl_en && req[owner] && !unit_done[owner]) |=> (busy && $stable(owner)));

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && unit_done[owner]) |=> !busy);

    assert_rr_hist_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (last == owner));
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [CH_COUNT-1:0] req,
    input  logic [CH_COUNT-1:0] unit_done,
    input  logic                ctl_en,
    input  logic                ctl_halt,
    input  logic [1:0]          ctl_mode,
    output logic [CH_COUNT-1:0] grant,
    output logic                grant_valid,
    output logic [IDX_W-1:0]    grant_idx
);
    pick_t   fixed_pick [FIXED_MODES];
    pick_t   rr_pick;
    pick_t   win;
    policy_e policy;
    logic    busy;
    ch_idx_t owner;
    ch_idx_t last;

    assign policy = policy_e'(ctl_mode);

    for (genvar m = 0; m < FIXED_MODES; m++) begin : g_fixed
        dma_arb_fixed_pick #(.POLICY(m)) u_pick (
            .req  (req),
            .pick (fixed_pick[m])
        );
    end

    dma_arb_rr_pick u_rr (
        .req  (req),
        .last (last),
        .pick (rr_pick)
    );

    always_comb begin
        case (policy)
            POL_ASCEND: win = fixed_pick[0];
            POL_TWO_UP: win = fixed_pick[1];
            POL_LEAD_2: win = fixed_pick[2];
            default:    win = rr_pick;
        endcase
    end

    dma_arb_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .unit_done (unit_done),
        .ctl_en    (ctl_en),
        .ctl_halt  (ctl_halt),
        .win       (win),
        .busy      (busy),
        .owner     (owner),
        .last      (last)
    );

    always_comb begin
        grant = '0;
        for (int c = 0; c < CH_COUNT; c++) begin
            if (busy && ctl_en && owner == ch_idx_t'(c) && req[c]) grant[c] = 1'b1;
        end
    end

    assign grant_valid = |grant;
    assign grant_idx   = grant_valid ? owner : '0;

    assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_req_R9: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    assert_enable_R6: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |-> (grant == '0));

    assert_idx_R10: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> grant[grant_idx]);
endmodule

// File: tb/dma_chan_arbiter_tb.sv
module dma_chan_arbiter_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] req = '0;
    logic [5:0] unit_done = '0;
    logic       ctl_en = 1'b0;
    logic       ctl_halt = 1'b0;
    logic [1:0] ctl_mode = 2'd0;
    logic [5:0] grant;
    logic       grant_valid;
    logic [2:0] grant_idx;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_chan_arbiter u_dut (
        .clk(clk), .rst(rst), .req(req), .unit_done(unit_done),
        .ctl_en(ctl_en), .ctl_halt(ctl_halt), .ctl_mode(ctl_mode),
        .grant(grant), .grant_valid(grant_valid), .grant_idx(grant_idx)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic ev, input int ei, input string tag);
        logic [5:0] eg;
        logic [2:0] ex;
        eg = ev ? (6'b1 << ei) : 6'b0;
        ex = ev ? 3'(ei) : 3'd0;
        checks++;
        if (grant !== eg || grant_valid !== ev || grant_idx !== ex) begin
            errors++;
            $display("FAIL %s: grant=%b valid=%b idx=%0d expected grant=%b valid=%b idx=%0d",
                     tag, grant, grant_valid, grant_idx, eg, ev, ex);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; req = '0; unit_done = '0;
        ctl_en = 1'b0; ctl_halt = 1'b0; ctl_mode = 2'd0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic release_ch(input int ch, input string tag);
        unit_done = 6'b1 << ch;
        step();
        unit_done = '0;
        check(1'b0, 0, tag);
    endtask

    task automatic grant_now(input logic [5:0] r, input int ei, input string tag);
        req = r;
        step();
        check(1'b1, ei, tag);
    endtask

    task automatic t_reset();
        do_reset();
        check(1'b0, 0, "R1 reset state");
        ctl_en = 1'b1; ctl_mode = 2'd3;
        grant_now(6'b111111, 0, "R1 rotation history starts at 5");
    endtask

    task automatic t_mode0();
        do_reset();
        ctl_en = 1'b1; ctl_mode = 2'd0;
        grant_now(6'b111111, 0, "R2 all request");
        release_ch(0, "R8 release");
        check(1'b0, 0, "R8 idle cycle");
        grant_now(6'b101000, 3, "R2 3 over 5");
        release_ch(3, "R8 release");
        grant_now(6'b100000, 5, "R2 only 5");
        release_ch(5, "R8 release");
    endtask

    task automatic t_mode1();
        do_reset();
        ctl_en = 1'b1; ctl_mode = 2'd1;
        grant_now(6'b001110, 2, "R3 2 over 3 and 1");
        release_ch(2, "R3 release");
        grant_now(6'b001010, 3, "R3 3 over 1");
        release_ch(3, "R3 release");
        grant_now(6'b110010, 1, "R3 1 over 4,5");
        release_ch(1, "R3 release");
    endtask

    task automatic t_mode2();
        do_reset();
        ctl_en = 1'b1; ctl_mode = 2'd2;
        grant_now(6'b111111, 2, "R4 2 first");
        release_ch(2, "R4 release");
        grant_now(6'b000011, 0, "R4 0 over 1");
        release_ch(0, "R4 release");
        grant_now(6'b111000, 3, "R4 3 over 4,5");
        release_ch(3, "R4 release");
    endtask

    task automatic t_rotate();
        do_reset();
        ctl_en = 1'b1; ctl_mode = 2'd3;
        for (int i = 0; i < 7; i++) begin
            grant_now(6'b111111, i % 6, "R5 full circle");
            release_ch(i % 6, "R5 release");
        end
        grant_now(6'b010010, 1, "R5 skip to 1");
        release_ch(1, "R5 release");
        grant_now(6'b010010, 4, "R5 skip to 4");
        release_ch(4, "R5 release");
        grant_now(6'b010010, 1, "R5 wrap to 1");
        release_ch(1, "R5 release");
    endtask

    task automatic t_hold();
        do_reset();
        ctl_en = 1'b1; ctl_mode = 2'd0;
        grant_now(6'b000100, 2, "R8 grant 2");
        req = 6'b000111;
        step();
        check(1'b1, 2, "R8 higher request ignored while held");
        unit_done = 6'b000001;
        step();
        unit_done = '0;
        check(1'b1, 2, "R8 other done ignored");
        req = 6'b000011;
        #1;
        check(1'b0, 0, "R9 dropped request removes grant");
        step();
        check(1'b0, 0, "R9 released after drop");
        step();
        check(1'b1, 0, "R9 rearbitrated");
        release_ch(0, "R9 release");
    endtask

    task automatic t_enable();
        do_reset();
        ctl_mode = 2'd0;
        req = 6'b111111;
        step(); step();
        check(1'b0, 0, "R6 disabled no grant");
        ctl_en = 1'b1;
        step();
        check(1'b1, 0, "R6 enabled grant");
        ctl_en = 1'b0;
        #1;
        check(1'b0, 0, "R6 grant withdrawn at once");
        step();
        ctl_en = 1'b1;
        #1;
        check(1'b0, 0, "R6 held grant released");
        step();
        check(1'b1, 0, "R6 regrant");
    endtask

    task automatic t_halt();
        do_reset();
        ctl_en = 1'b1; ctl_halt = 1'b1; ctl_mode = 2'd0;
        req = 6'b000110;
        step(); step();
        check(1'b0, 0, "R7 halt blocks grant");
        ctl_halt = 1'b0;
        step();
        check(1'b1, 1, "R7 grant after halt clears");
        ctl_halt = 1'b1;
        step(); step();
        check(1'b1, 1, "R7 held grant survives halt");
        release_ch(1, "R7 release under halt");
        step();
        check(1'b0, 0, "R7 no new grant under halt");
        ctl_halt = 1'b0;
        step();
        check(1'b1, 1, "R7 grant after halt");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_mode0();
        t_mode1();
        t_mode2();
        t_rotate();
        t_hold();
        t_enable();
        t_halt();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule